// File: doc/BRIEF.md
# SpaceWire character transmitter

This block is the bit-level sending side of a SpaceWire link. Link control logic asks it for one of three things through separate level requests: a Time-code with an 8-bit time value, a flow-control token (FCT), or an N-Char. The N-Char value is 9 bits wide, and its top bit marks an end-of-packet marker instead of a data byte. The block turns each request into line characters. It works out the parity and the data/control flag for each character, adds the escape prefix where one is needed, and drives the result onto a data/strobe pair for external line drivers.

When no request is waiting and the block is enabled, it fills every slot with NULLs. This keeps the link busy between characters. Each request that wins arbitration gets a one-cycle acknowledge at the moment its first bit goes onto the line. The requester holds its request and value until that acknowledge arrives. Clearing the enable input silences the line at once and clears the parity history.

Top module: `spw_char_tx`

## Requirements
- R1: While `rst` is high, or `en` was low at the previous clock edge, `tx_d` and `tx_s` are both 0. Disabling the block clears the parity history, so the first character after enabling takes its parity as if the previous character's bits were all zero.
- R2: A data character is 10 bits on the line, sent in this order: parity, then flag 0, then the 8 data bits least significant first. An N-Char with `nc_val[8]`=0 is sent as a data character carrying `nc_val[7:0]`.
- R3: A control character is 4 bits, sent in this order: parity, then flag 1, then two code bits written left to right in line order: FCT "00", EOP "01", EEP "10", ESC "11". An N-Char with `nc_val[8]`=1 is sent as EEP when `nc_val[0]`=1 and as EOP otherwise, and `nc_val[7:1]` has no effect on it.
- R4: The parity bit of each character is chosen so that the data or code bits of the previous character, together with the current parity and flag bits, contain an odd number of ones.
- R5: While enabled with no request pending, the block sends NULLs back to back. A NULL is ESC followed by FCT.
- R6: A Time-code is sent as ESC followed by a data character that carries `tc_val`.
- R7: Each bit lasts `BIT_CYC` clock cycles. At each bit boundary exactly one of `tx_d` and `tx_s` changes: `tx_s` toggles when the new data bit equals the old one.
- R8: When more than one request is pending at a character boundary, the Time-code is taken first, then the FCT, then the N-Char.
- R9: An accepted request is acknowledged by a one-cycle pulse on its own ack output. The pulse appears in the same cycle that the character's first bit is driven. Only a request that was asserted at that edge is acknowledged, and every acknowledged request is sent exactly once.
- R10: No acknowledge is given while the block is disabled, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Transmitter enable |
| tc_req | input | 1 | Time-code request, held until `tc_ack` |
| tc_val | input | 8 | Time value for the Time-code |
| fct_req | input | 1 | FCT request, held until `fct_ack` |
| nc_req | input | 1 | N-Char request, held until `nc_ack` |
| nc_val | input | 9 | N-Char value; bit 8 set selects EOP/EEP |
| tc_ack | output | 1 | Time-code accepted |
| fct_ack | output | 1 | FCT accepted |
| nc_ack | output | 1 | N-Char accepted |
| tx_d | output | 1 | Line data |
| tx_s | output | 1 | Line strobe |

## Verification
The bench decodes the data/strobe pair on its own and rebuilds the stream of characters from it. It checks that the two lines never change together and that each bit lasts `BIT_CYC` cycles. It checks parity across character boundaries, including the step from an escape into the character that follows it. A design that took parity over the current character, or that kept the old history after a disable, fails parity right after ESC or on the first character after re-enabling.

Requests that arrive together, and a Time-code held pending through a disabled window, show whether the priority order is wrong, whether a request is acknowledged while the block is disabled, and whether an acknowledge is lost or repeated. Each of these shows up as a missing, duplicated or reordered character. EOP and EEP are sent with junk in the ignored low bits, to catch a design that mistakes one for the other.

// File: rtl/spw_tx_pkg.sv
package spw_tx_pkg;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned DCHAR_LEN = DATA_W + 2;
  localparam int unsigned CCHAR_LEN = 4;
  localparam int unsigned SLOT_MAX  = CCHAR_LEN + DCHAR_LEN;
  localparam int unsigned LEN_W     = $clog2(SLOT_MAX + 1);

  // Two code bits, left bit goes on the line first.
  typedef logic [1:0] ccode_t;
  localparam ccode_t CODE_FCT = 2'b00;
  localparam ccode_t CODE_EOP = 2'b01;
  localparam ccode_t CODE_EEP = 2'b10;
  localparam ccode_t CODE_ESC = 2'b11;

  typedef enum logic [1:0] {PICK_NULL, PICK_TIME, PICK_FCT, PICK_NCHAR} pick_e;

  // Vectors are stored with bit 0 being the first bit on the line.
  function automatic logic [CCHAR_LEN-1:0] ctrl_vec(input ccode_t code, input logic par);
    return {code[0], code[1], 1'b1, par};
  endfunction

  function automatic logic [DCHAR_LEN-1:0] data_vec(input logic [DATA_W-1:0] v, input logic par);
    return {v, 1'b0, par};
  endfunction
endpackage

// File: rtl/spw_tx_format.sv
module spw_tx_format import spw_tx_pkg::*; (
  input  logic                tc_req,
  input  logic [DATA_W-1:0]   tc_val,
  input  logic                fct_req,
  input  logic                nc_req,
  input  logic [DATA_W:0]     nc_val,
  input  logic                hist,
  output pick_e               pick,
  output logic [SLOT_MAX-1:0] slot,
  output logic [LEN_W-1:0]    slot_len,
  output logic                slot_hist
);
  // hist is the xor of the previous character's data/code bits.
  // Parity = ~(hist ^ flag) gives an odd count over the window.
  always_comb begin
    pick      = PICK_NULL;
    slot      = '0;
    slot_len  = LEN_W'(2 * CCHAR_LEN);
    slot_hist = 1'b0;
    if (tc_req) begin
      pick      = PICK_TIME;
      // ESC bits xor to 0, data flag 0: parity of the data char is 1
      slot      = SLOT_MAX'({data_vec(tc_val, 1'b1), ctrl_vec(CODE_ESC, hist)});
      slot_len  = LEN_W'(SLOT_MAX);
      slot_hist = ^tc_val;
    end else if (fct_req) begin
      pick      = PICK_FCT;
      slot      = SLOT_MAX'(ctrl_vec(CODE_FCT, hist));
      slot_len  = LEN_W'(CCHAR_LEN);
      slot_hist = 1'b0;
    end else if (nc_req) begin
      pick = PICK_NCHAR;
      if (nc_val[DATA_W]) begin
        slot      = SLOT_MAX'(ctrl_vec(nc_val[0] ? CODE_EEP : CODE_EOP, hist));
        slot_len  = LEN_W'(CCHAR_LEN);
        slot_hist = 1'b1;
      end else begin
        slot      = SLOT_MAX'(data_vec(nc_val[DATA_W-1:0], ~hist));
        slot_len  = LEN_W'(DCHAR_LEN);
        slot_hist = ^nc_val[DATA_W-1:0];
      end
    end else begin
      // NULL: ESC then FCT; FCT after ESC has parity 0
      slot      = SLOT_MAX'({ctrl_vec(CODE_FCT, 1'b0), ctrl_vec(CODE_ESC, hist)});
      slot_len  = LEN_W'(2 * CCHAR_LEN);
      slot_hist = 1'b0;
    end
  end
endmodule

// File: rtl/spw_tx_shifter.sv
module spw_tx_shifter import spw_tx_pkg::*; #(
  parameter int unsigned BIT_CYC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  pick_e               pick,
  input  logic [SLOT_MAX-1:0] slot,
  input  logic [LEN_W-1:0]    slot_len,
  input  logic                slot_hist,
  output logic                hist,
  output logic                bit_val,
  output logic                bit_stb,
  output logic                ack_tc,
  output logic                ack_fct,
  output logic                ack_nc
);
  localparam int unsigned DIV_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;

  logic [DIV_W-1:0]    div_q;
  logic [SLOT_MAX-1:0] sh_q;
  logic [LEN_W-1:0]    rem_q;
  logic                boundary;

  assign boundary = (rem_q == '0);
  assign bit_stb  = en && (div_q == DIV_W'(BIT_CYC - 1));
  assign bit_val  = boundary ? slot[0] : sh_q[0];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q   <= '0;
      sh_q    <= '0;
      rem_q   <= '0;
      hist    <= 1'b0;
      ack_tc  <= 1'b0;
      ack_fct <= 1'b0;
      ack_nc  <= 1'b0;
    end else begin
      ack_tc  <= 1'b0;
      ack_fct <= 1'b0;
      ack_nc  <= 1'b0;
      div_q   <= bit_stb ? '0 : div_q + DIV_W'(1);
      if (bit_stb) begin
        if (boundary) begin
          sh_q    <= slot >> 1;
          rem_q   <= slot_len - LEN_W'(1);
          hist    <= slot_hist;
          ack_tc  <= (pick == PICK_TIME);
          ack_fct <= (pick == PICK_FCT);
          ack_nc  <= (pick == PICK_NCHAR);
        end else begin
          sh_q  <= sh_q >> 1;
          rem_q <= rem_q - LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spw_tx_ds_enc.sv
module spw_tx_ds_enc (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_stb,
  input  logic bit_val,
  output logic tx_d,
  output logic tx_s
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tx_d <= 1'b0;
      tx_s <= 1'b0;
    end else if (bit_stb) begin
      tx_d <= bit_val;
      if (bit_val == tx_d) tx_s <= ~tx_s;
    end
  end
endmodule

// File: rtl/spw_char_tx.sv
module spw_char_tx import spw_tx_pkg::*; #(
  parameter int unsigned BIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tc_req,
  input  logic [DATA_W-1:0] tc_val,
  input  logic              fct_req,
  input  logic              nc_req,
  input  logic [DATA_W:0]   nc_val,
  output logic              tc_ack,
  output logic              fct_ack,
  output logic              nc_ack,
  output logic              tx_d,
  output logic              tx_s
);
  pick_e               pick;
  logic [SLOT_MAX-1:0] slot;
  logic [LEN_W-1:0]    slot_len;
  logic                slot_hist;
  logic                hist;
  logic                bit_val;
  logic                bit_stb;

  spw_tx_format u_format (
    .tc_req(tc_req), .tc_val(tc_val), .fct_req(fct_req), .nc_req(nc_req),
    .nc_val(nc_val), .hist(hist), .pick(pick), .slot(slot),
    .slot_len(slot_len), .slot_hist(slot_hist)
  );

  spw_tx_shifter #(.BIT_CYC(BIT_CYC)) u_shifter (
    .clk(clk), .rst(rst), .en(en), .pick(pick), .slot(slot),
    .slot_len(slot_len), .slot_hist(slot_hist), .hist(hist),
    .bit_val(bit_val), .bit_stb(bit_stb),
    .ack_tc(tc_ack), .ack_fct(fct_ack), .ack_nc(nc_ack)
  );

  spw_tx_ds_enc u_ds (
    .clk(clk), .rst(rst), .en(en), .bit_stb(bit_stb), .bit_val(bit_val),
    .tx_d(tx_d), .tx_s(tx_s)
  );
endmodule

// File: rtl/spw_char_tx_chk.sv
module spw_char_tx_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tc_req,
  input logic fct_req,
  input logic nc_req,
  input logic tc_ack,
  input logic fct_ack,
  input logic nc_ack,
  input logic tx_d,
  input logic tx_s
);
  a_r1_lines_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!tx_d && !tx_s));

  a_r7_single_toggle: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> !((tx_d != $past(tx_d)) && (tx_s != $past(tx_s))));

  a_r8_fct_yields: assert property (@(posedge clk) disable iff (rst)
    fct_ack |-> !$past(tc_req));

  a_r8_nc_yields: assert property (@(posedge clk) disable iff (rst)
    nc_ack |-> (!$past(tc_req) && !$past(fct_req)));

  a_r9_tc_needs_req: assert property (@(posedge clk) disable iff (rst)
    tc_ack |-> $past(tc_req));

  a_r9_fct_needs_req: assert property (@(posedge clk) disable iff (rst)
    fct_ack |-> $past(fct_req));

  a_r9_nc_needs_req: assert property (@(posedge clk) disable iff (rst)
    nc_ack |-> $past(nc_req));

  a_r9_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tc_ack, fct_ack, nc_ack}));

  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    (tc_ack || fct_ack || nc_ack) |=> !(tc_ack || fct_ack || nc_ack));

  a_r10_no_ack_off: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !(tc_ack || fct_ack || nc_ack));
endmodule

bind spw_char_tx spw_char_tx_chk u_chk (.*);

// File: tb/spw_char_tx_bench.sv
module spw_char_tx_bench;
  localparam int BIT_CYC = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, en = 1'b0;
  logic tc_req = 1'b0, fct_req = 1'b0, nc_req = 1'b0;
  logic [7:0] tc_val = '0;
  logic [8:0] nc_val = '0;
  logic tc_ack, fct_ack, nc_ack, tx_d, tx_s;

  spw_char_tx #(.BIT_CYC(BIT_CYC)) u_spw_char_tx (
    .clk(clk), .rst(rst), .en(en), .tc_req(tc_req), .tc_val(tc_val),
    .fct_req(fct_req), .nc_req(nc_req), .nc_val(nc_val),
    .tc_ack(tc_ack), .fct_ack(fct_ack), .nc_ack(nc_ack),
    .tx_d(tx_d), .tx_s(tx_s)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Inputs as the design saw them at the last edge.
  logic r_tc, r_fct, r_nc;
  logic [7:0] r_tcv;
  logic [8:0] r_ncv;
  always @(posedge clk) begin
    r_tc <= tc_req; r_fct <= fct_req; r_nc <= nc_req;
    r_tcv <= tc_val; r_ncv <= nc_val;
  end

  function automatic logic [8:0] norm_nc(input logic [8:0] v);
    return v[8] ? {1'b1, 7'b0, v[0]} : v;
  endfunction

  // Item: {kind, value}; kind 0 FCT, 1 N-Char, 2 Time-code
  logic [10:0] exp_q[$];
  logic [13:0] cbuf;
  int ccnt = 0;
  logic hx = 1'b0, esc = 1'b0;
  int nulls = 0;
  logic pd = 1'b0, ps = 1'b0, started = 1'b0, prev_off = 1'b0;
  int gap = 0;

  task automatic emit(input logic [10:0] item);
    logic [10:0] e;
    string tag;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", "unrequested character", int'(item), 0);
    end else begin
      e = exp_q.pop_front();
      tag = (e[10:9] == 2'd2) ? "R6" : (e[10:9] == 2'd0 || e[8]) ? "R3" : "R2";
      check(item == e, tag, "decoded character", int'(item), int'(e));
    end
  endtask

  task automatic finish_char();
    logic [1:0] code;
    logic [7:0] dv;
    check((cbuf[0] ^ cbuf[1] ^ hx) == 1'b1, "R4", "odd parity", int'(cbuf[1:0]), int'(hx));
    if (cbuf[1]) begin
      code = {cbuf[2], cbuf[3]};
      hx = cbuf[2] ^ cbuf[3];
      if (esc) begin
        esc = 1'b0;
        if (code == 2'b00) nulls++;
        else check(1'b0, "R3", "code after escape", int'(code), 0);
      end else begin
        case (code)
          2'b11: esc = 1'b1;
          2'b00: emit({2'd0, 9'd0});
          2'b01: emit({2'd1, 9'h100});
          default: emit({2'd1, 9'h101});
        endcase
      end
    end else begin
      dv = cbuf[9:2];
      hx = ^dv;
      if (esc) begin esc = 1'b0; emit({2'd2, 1'b0, dv}); end
      else emit({2'd1, 1'b0, dv});
    end
  endtask

  // Line decoder and acknowledge monitor.
  always @(negedge clk) begin
    if (rst || !en) begin
      if (prev_off)
        check(!tx_d && !tx_s && !tc_ack && !fct_ack && !nc_ack, "R1",
              "quiet while off (R10 no ack)", int'({tx_d, tx_s, tc_ack, fct_ack, nc_ack}), 0);
      prev_off = 1'b1;
      pd = 1'b0; ps = 1'b0; ccnt = 0; hx = 1'b0; esc = 1'b0;
      started = 1'b0; gap = 0;
      exp_q.delete();
    end else begin
      prev_off = 1'b0;
      gap++;
      if (tc_ack) begin
        check(r_tc, "R9", "tc ack without request", 1, 0);
        exp_q.push_back({2'd2, 1'b0, r_tcv});
      end
      if (fct_ack) begin
        check(r_fct && !r_tc, "R8", "fct ack priority", int'({r_tc, r_fct}), 1);
        exp_q.push_back({2'd0, 9'd0});
      end
      if (nc_ack) begin
        check(r_nc && !r_tc && !r_fct, "R8", "nchar ack priority",
              int'({r_tc, r_fct, r_nc}), 1);
        exp_q.push_back({2'd1, norm_nc(r_ncv)});
      end
      if ((tx_d != pd) && (tx_s != ps)) begin
        check(1'b0, "R7", "both lines toggled", 3, 1);
      end else if ((tx_d != pd) || (tx_s != ps)) begin
        if (started) check(gap == BIT_CYC, "R7", "bit period", gap, BIT_CYC);
        started = 1'b1;
        gap = 0;
        cbuf[ccnt] = tx_d;
        ccnt++;
        if (ccnt >= 2 && ccnt == (cbuf[1] ? 4 : 10)) begin
          finish_char();
          ccnt = 0;
        end
      end
      pd = tx_d; ps = tx_s;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(input int kind, input logic [8:0] v);
    bit got = 1'b0;
    if (kind == 2) begin tc_val = v[7:0]; tc_req = 1'b1; end
    else if (kind == 0) fct_req = 1'b1;
    else begin nc_val = v; nc_req = 1'b1; end
    for (int i = 0; i < 400 && !got; i++) begin
      step(1);
      got = (kind == 2) ? tc_ack : (kind == 0) ? fct_ack : nc_ack;
    end
    check(got, "R9", "ack arrives", int'(got), 1);
    tc_req = 1'b0; fct_req = 1'b0; nc_req = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) step(1);
    step(40);
    check(exp_q.size() == 0, "R9", "all acked characters sent", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n0;
    string order;
    void'($urandom(32'd2024));
    step(4);
    rst = 1'b0;
    tc_req = 1'b1; tc_val = 8'h5A;
    step(6);
    // R1 / R10: held request while disabled gets nothing
    check(!tx_d && !tx_s && !tc_ack, "R10", "no ack while disabled",
          int'({tx_d, tx_s, tc_ack}), 0);
    tc_req = 1'b0;

    // R5: idle NULLs
    en = 1'b1;
    n0 = nulls;
    step(300);
    check(nulls - n0 >= 15, "R5", "idle nulls sent", nulls - n0, 15);

    // Directed characters, R2 R3 R6
    send(2, 9'h000);
    send(2, 9'h0FF);
    send(0, 9'h000);
    send(1, 9'h0A5);
    send(1, 9'h000);
    send(1, 9'h1FE);   // EOP with junk bits (R3)
    send(1, 9'h1AB);   // EEP with junk bits (R3)
    send(1, 9'h0FF);
    wait_drain();

    // R8: all three together
    order = "";
    tc_val = 8'h3C; nc_val = 9'h081;
    tc_req = 1'b1; fct_req = 1'b1; nc_req = 1'b1;
    for (int i = 0; i < 600 && (tc_req || fct_req || nc_req); i++) begin
      step(1);
      if (tc_ack)  begin tc_req = 1'b0;  order = {order, "T"}; end
      if (fct_ack) begin fct_req = 1'b0; order = {order, "F"}; end
      if (nc_ack)  begin nc_req = 1'b0;  order = {order, "N"}; end
    end
    check(order == "TFN", "R8", "ack order T,F,N", int'(order.len()), 3);
    wait_drain();

    // R1: disable mid character, request pending through the gap
    send(1, 9'h0C3);
    step(3);
    en = 1'b0;
    tc_val = 8'h96; tc_req = 1'b1;
    step(8);
    check(!tc_ack && !tx_d && !tx_s, "R1", "disabled lines low", int'({tc_ack, tx_d, tx_s}), 0);
    en = 1'b1;
    for (int i = 0; i < 50 && tc_req; i++) begin
      step(1);
      if (tc_ack) tc_req = 1'b0;
    end
    check(!tc_req, "R9", "ack after re-enable", int'(tc_req), 0);
    wait_drain();

    // Random mix
    for (int c = 0; c < 6000; c++) begin
      step(1);
      if (tc_req) begin if (tc_ack) tc_req = 1'b0; end
      else if ($urandom_range(0, 40) == 0) begin tc_val = 8'($urandom); tc_req = 1'b1; end
      if (fct_req) begin if (fct_ack) fct_req = 1'b0; end
      else if ($urandom_range(0, 30) == 0) fct_req = 1'b1;
      if (nc_req) begin if (nc_ack) nc_req = 1'b0; end
      else if ($urandom_range(0, 10) == 0) begin
        nc_val = 9'($urandom);
        nc_val[8] = ($urandom_range(0, 3) == 0);
        nc_req = 1'b1;
      end
    end
    for (int i = 0; i < 2000 && (tc_req || fct_req || nc_req); i++) begin
      step(1);
      if (tc_ack) tc_req = 1'b0;
      if (fct_ack) fct_req = 1'b0;
      if (nc_ack) nc_req = 1'b0;
    end
    wait_drain();

    summary();
    $finish;
  end
endmodule